// File: doc/BRIEF.md
# Per-Channel Credit Tracker with Downstream Return Loop

This block sits on the sending end of a link that carries several virtual channels (VCs). It holds one credit counter per downstream VC. Each counter starts at the number of buffer slots that VC has downstream. A flit offered on a VC is accepted only while that VC still holds credit. An accepted flit takes one credit away. A credit that comes back from downstream puts one credit back.

The block also contains a small model of the downstream buffer, so that the whole credit loop can be exercised. Accepted flits reach it one cycle after acceptance. When the receiver frees a slot, the model emits one credit for that VC. Returned credits travel back through a delay line whose depth is a parameter. This shows how the round-trip time, set against the buffer depth, limits throughput.

The sender offers one flit per cycle, tagged with its VC. `send_fire_o` tells it, in the same cycle, whether the flit was taken. The receiver side raises one drain bit per VC to free a slot.

Top module: `credit_link_tracker`

## Requirements
- R1: After reset, every VC counter equals BUF_DEPTH, every `send_ok_o` bit is 1, every downstream occupancy is 0, and `send_fire_o` is 0.
- R2: `send_fire_o` is 1 in the same cycle exactly when `send_valid_i` is 1 and the counter of VC `send_vc_i` is nonzero.
- R3: An accepted flit lowers the counter of its VC by one at the next rising edge, and leaves every other VC's counter unchanged.
- R4: While a VC's counter is 0, its `send_ok_o` bit is 0. A flit offered on that VC is not accepted, the counter stays 0, and no flit reaches that VC's downstream buffer.
- R5: An accepted flit adds one to the downstream occupancy of its VC on the second rising edge, counting the edge at which it was accepted.
- R6: A drain bit sampled at a rising edge while that VC's occupancy is nonzero does two things. It lowers that occupancy at that edge. It raises that VC's counter by one on edge RET_LAT+1, counting the sampling edge as edge 1.
- R7: A drain bit on a VC whose occupancy is 0 frees nothing and returns no credit. The counter and the occupancy of that VC stay unchanged.
- R8: When an accepted flit and a returning credit hit the same VC at the same edge, that VC's counter is unchanged.
- R9: No counter and no occupancy ever exceeds BUF_DEPTH. For each VC, counter plus occupancy never exceeds BUF_DEPTH.
- R10: With BUF_DEPTH=6 and RET_LAT=2, a sender that offers on one VC every cycle, while that VC is drained every cycle, is accepted every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| send_valid_i | input | 1 | Sender offers a flit this cycle |
| send_vc_i | input | VCW | VC of the offered flit |
| send_fire_o | output | 1 | Offered flit accepted this cycle |
| send_ok_o | output | NUM_VC | Per-VC credit available |
| drain_i | input | NUM_VC | Receiver frees one slot per set bit |
| credit_cnt_o | output | NUM_VC*CW | Per-VC credit counters, VC v at bits [v*CW +: CW] |
| ds_occ_o | output | NUM_VC*CW | Per-VC downstream occupancy, VC v at bits [v*CW +: CW] |

## Verification
Each result has its own latency:
- `send_fire_o` depends on the current inputs alone, so it is read 1 ns after the inputs change, before the edge.
- A counter drop is due one edge after acceptance.
- A new flit appears in the occupancy two edges after acceptance.
- A returned credit is due RET_LAT+1 edges after the drain is sampled.

The bench keeps a per-cycle expectation that applies these delays in order. It compares every counter, every occupancy and every `send_ok_o` bit at each falling edge. Directed sequences also read the counters 1 ns after each edge. These follow the drain latency edge by edge and line up a send with a returning credit on the same edge.

// File: rtl/credit_pkg.sv
package credit_pkg;
  function automatic int unsigned cnt_width(input int unsigned depth);
    return (depth < 1) ? 1 : $clog2(depth + 1);
  endfunction

  function automatic int unsigned idx_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/credit_counter.sv
module credit_counter #(
  parameter int unsigned DEPTH = 6,
  parameter int unsigned CW    = credit_pkg::cnt_width(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          take_i,
  input  logic          give_i,
  output logic [CW-1:0] cnt_o,
  output logic          avail_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= CW'(DEPTH);
    else if (take_i && !give_i) cnt_q <= cnt_q - 1'b1;
    else if (give_i && !take_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o   = cnt_q;
  assign avail_o = (cnt_q != '0);

  // R4
  no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |-> (cnt_q != '0));
  // R9
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (give_i && !take_i) |-> (cnt_q < CW'(DEPTH)));
  // R3
  take_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && !give_i) |=> (cnt_q == $past(cnt_q) - 1'b1));
  // R8
  same_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && give_i) |=> (cnt_q == $past(cnt_q)));
endmodule

// File: rtl/credit_return_pipe.sv
module credit_return_pipe #(
  parameter int unsigned NUM_VC = 4,
  parameter int unsigned LAT    = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_VC-1:0] pulse_i,
  output logic [NUM_VC-1:0] pulse_o
);
  if (LAT == 0) begin : g_wire
    assign pulse_o = pulse_i;
  end else begin : g_regs
    logic [NUM_VC-1:0] stg_q [LAT];
    for (genvar s = 0; s < LAT; s++) begin : g_stg
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= '0;
        else if (s == 0) stg_q[s] <= pulse_i;
        else stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
      end
    end
    assign pulse_o = stg_q[LAT-1];
  end
endmodule

// File: rtl/ds_slot_model.sv
module ds_slot_model #(
  parameter int unsigned NUM_VC = 4,
  parameter int unsigned DEPTH  = 6,
  parameter int unsigned CW     = credit_pkg::cnt_width(DEPTH)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_VC-1:0]    arrive_i,
  input  logic [NUM_VC-1:0]    drain_i,
  output logic [NUM_VC*CW-1:0] occ_o,
  output logic [NUM_VC-1:0]    freed_o
);
  logic [NUM_VC-1:0] link_q;  // one cycle of link propagation

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) link_q <= '0;
    else         link_q <= arrive_i;
  end

  for (genvar v = 0; v < NUM_VC; v++) begin : g_vc
    logic [CW-1:0] occ_q;
    assign freed_o[v] = drain_i[v] && (occ_q != '0);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                      occ_q <= '0;
      else if (link_q[v] && !freed_o[v]) occ_q <= occ_q + 1'b1;
      else if (freed_o[v] && !link_q[v]) occ_q <= occ_q - 1'b1;
    end
    assign occ_o[v*CW +: CW] = occ_q;

    // R9
    occ_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (link_q[v] && !freed_o[v]) |-> (occ_q < CW'(DEPTH)));
    // R7
    empty_drain_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (occ_q == '0 && !link_q[v]) |=> (occ_q == '0));
  end
endmodule

// File: rtl/credit_link_tracker.sv
module credit_link_tracker #(
  parameter int unsigned NUM_VC    = 4,
  parameter int unsigned BUF_DEPTH = 6,
  parameter int unsigned RET_LAT   = 2,
  localparam int unsigned VCW = credit_pkg::idx_width(NUM_VC),
  localparam int unsigned CW  = credit_pkg::cnt_width(BUF_DEPTH)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 send_valid_i,
  input  logic [VCW-1:0]       send_vc_i,
  output logic                 send_fire_o,
  output logic [NUM_VC-1:0]    send_ok_o,
  input  logic [NUM_VC-1:0]    drain_i,
  output logic [NUM_VC*CW-1:0] credit_cnt_o,
  output logic [NUM_VC*CW-1:0] ds_occ_o
);
  logic [NUM_VC-1:0] avail, take, freed, ret;

  always_comb begin
    take = '0;
    for (int v = 0; v < NUM_VC; v++)
      take[v] = send_valid_i && (send_vc_i == VCW'(v)) && avail[v];
  end
  assign send_fire_o = |take;
  assign send_ok_o   = avail;

  for (genvar v = 0; v < NUM_VC; v++) begin : g_cnt
    credit_counter #(.DEPTH(BUF_DEPTH), .CW(CW)) u_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .take_i (take[v]),
      .give_i (ret[v]),
      .cnt_o  (credit_cnt_o[v*CW +: CW]),
      .avail_o(avail[v])
    );

    // R9
    credit_conserve_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ({1'b0, credit_cnt_o[v*CW +: CW]} + {1'b0, ds_occ_o[v*CW +: CW]})
        <= (CW+1)'(BUF_DEPTH));
  end

  ds_slot_model #(.NUM_VC(NUM_VC), .DEPTH(BUF_DEPTH), .CW(CW)) u_ds (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .arrive_i(take),
    .drain_i (drain_i),
    .occ_o   (ds_occ_o),
    .freed_o (freed)
  );

  credit_return_pipe #(.NUM_VC(NUM_VC), .LAT(RET_LAT)) u_ret (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pulse_i(freed),
    .pulse_o(ret)
  );

  // R2
  fire_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(take) && (send_fire_o -> send_valid_i));
endmodule

// File: tb/credit_link_tracker_tb_top.sv
module credit_link_tracker_tb_top;
  localparam int NV = 4, DEP = 6, LAT = 2, CW = 3, VW = 2;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic            rst_ni = 1'b0;
  logic            send_valid_i = 1'b0;
  logic [VW-1:0]   send_vc_i = '0;
  logic [NV-1:0]   drain_i = '0;
  logic            send_fire_o;
  logic [NV-1:0]   send_ok_o;
  logic [NV*CW-1:0] credit_cnt_o, ds_occ_o;

  credit_link_tracker #(.NUM_VC(NV), .BUF_DEPTH(DEP), .RET_LAT(LAT)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .send_valid_i(send_valid_i), .send_vc_i(send_vc_i),
    .send_fire_o(send_fire_o), .send_ok_o(send_ok_o), .drain_i(drain_i),
    .credit_cnt_o(credit_cnt_o), .ds_occ_o(ds_occ_o));

  int checks = 0, fails = 0;
  int exp_cnt [NV];
  int exp_occ [NV];
  logic [NV-1:0] ret_q [LAT];
  logic [NV-1:0] arr_q = '0;
  int fire_total = 0;

  // stimulus: {valid, vc[1:0], drain[3:0], repeat[3:0]}
  localparam int NSTIM = 12;
  localparam logic [10:0] STIM [NSTIM] = '{
    {1'b1, 2'd0, 4'b0000, 4'd3},
    {1'b1, 2'd1, 4'b0000, 4'd2},
    {1'b0, 2'd0, 4'b0001, 4'd2},
    {1'b1, 2'd3, 4'b0010, 4'd4},
    {1'b1, 2'd2, 4'b1000, 4'd7},
    {1'b0, 2'd0, 4'b0100, 4'd3},
    {1'b1, 2'd1, 4'b0011, 4'd5},
    {1'b0, 2'd0, 4'b0000, 4'd3},
    {1'b1, 2'd0, 4'b1111, 4'd6},
    {1'b1, 2'd3, 4'b0000, 4'd8},
    {1'b0, 2'd0, 4'b1111, 4'd9},
    {1'b1, 2'd2, 4'b0100, 4'd4}
  };

  function automatic int cnt_of(int v); return int'(credit_cnt_o[v*CW +: CW]); endfunction
  function automatic int occ_of(int v); return int'(ds_occ_o[v*CW +: CW]); endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_state();
    for (int v = 0; v < NV; v++) begin
      chk("R3 credit count", cnt_of(v), exp_cnt[v]);
      chk("R5 downstream occupancy", occ_of(v), exp_occ[v]);
      chk("R4 send_ok", int'(send_ok_o[v]), int'(exp_cnt[v] != 0));
      chk("R9 count bound", int'(cnt_of(v) + occ_of(v) <= DEP), 1);
    end
  endtask

  task automatic step(input logic valid, input logic [VW-1:0] vc, input logic [NV-1:0] drain);
    logic fire;
    logic [NV-1:0] raw;
    @(negedge clk);
    check_state();
    send_valid_i = valid; send_vc_i = vc; drain_i = drain;
    #1;
    fire = valid && (exp_cnt[vc] > 0);
    chk("R2 send_fire", int'(send_fire_o), int'(fire));
    if (send_fire_o) fire_total++;
    @(posedge clk);
    for (int v = 0; v < NV; v++) raw[v] = drain[v] && (exp_occ[v] > 0);
    for (int v = 0; v < NV; v++) begin
      exp_cnt[v] = exp_cnt[v] + int'(ret_q[LAT-1][v]) - int'(fire && (int'(vc) == v));
      exp_occ[v] = exp_occ[v] + int'(arr_q[v]) - int'(raw[v]);
    end
    for (int i = LAT-1; i > 0; i--) ret_q[i] = ret_q[i-1];
    ret_q[0] = raw;
    arr_q = fire ? (NV'(1) << vc) : '0;
  endtask

  task automatic flush();
    for (int i = 0; i < 16; i++) step(1'b0, '0, '1);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int c_before;
    for (int v = 0; v < NV; v++) begin exp_cnt[v] = DEP; exp_occ[v] = 0; end
    for (int i = 0; i < LAT; i++) ret_q[i] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    for (int v = 0; v < NV; v++) begin
      chk("R1 reset count", cnt_of(v), DEP);
      chk("R1 reset occupancy", occ_of(v), 0);
    end
    chk("R1 reset send_ok", int'(send_ok_o), (1 << NV) - 1);
    chk("R1 reset fire", int'(send_fire_o), 0);
    rst_ni = 1'b1;

    // table walk
    for (int n = 0; n < NSTIM; n++)
      for (int r = 0; r < int'(STIM[n][3:0]); r++)
        step(STIM[n][10], STIM[n][9:8], STIM[n][7:4]);
    flush();

    // R4: exhaust VC2, keep offering
    for (int i = 0; i < DEP + 3; i++) step(1'b1, 2'd2, '0);
    #1;
    chk("R4 exhausted send_ok", int'(send_ok_o[2]), 0);
    chk("R4 exhausted count", cnt_of(2), 0);
    step(1'b0, '0, '0);
    #1;
    chk("R4 no extra arrival", occ_of(2), DEP);
    flush();

    // R7: drain on empty VC3
    for (int i = 0; i < LAT + 2; i++) begin
      step(1'b0, '0, 4'b1000);
      #1;
      chk("R7 empty drain count", cnt_of(3), DEP);
      chk("R7 empty drain occupancy", occ_of(3), 0);
    end

    // R6: credit return latency on VC1
    step(1'b1, 2'd1, '0);
    step(1'b0, '0, '0);
    step(1'b0, '0, '0);
    step(1'b0, '0, 4'b0010);          // drain sampled at edge 1
    #1;
    chk("R6 occupancy after drain", occ_of(1), 0);
    chk("R6 count at edge 1", cnt_of(1), DEP - 1);
    step(1'b0, '0, '0);
    #1;
    chk("R6 count at edge 2", cnt_of(1), DEP - 1);
    step(1'b0, '0, '0);
    #1;
    chk("R6 count at edge 3", cnt_of(1), DEP);
    flush();

    // R8: send and credit return on VC0 at the same edge
    step(1'b1, 2'd0, '0);
    step(1'b0, '0, '0);
    step(1'b0, '0, 4'b0001);
    step(1'b0, '0, '0);
    #1;
    c_before = cnt_of(0);
    chk("R8 count before coincidence", c_before, DEP - 1);
    step(1'b1, 2'd0, '0);
    #1;
    chk("R8 coincident send and return", cnt_of(0), c_before);
    flush();

    // R10: sustained throughput on VC0
    fire_total = 0;
    for (int i = 0; i < 30; i++) step(1'b1, 2'd0, 4'b0001);
    chk("R10 accepted every cycle", fire_total, 30);
    flush();
    step(1'b0, '0, '0);

    summary();
    $finish;
  end
endmodule